// File: doc/BRIEF.md
# Ten-to-N Pixel Lane Re-gearer

This block takes a wide pixel word of ten 10-bit pixels per accepted beat and puts it out as 3, 6 or 8 parallel 8-bit pixel lanes per clock. Each pixel loses its two lowest bits on entry, so a beat carries 80 bits of payload. A two-bit tap mode picks the output width: narrow (3 lanes), middle (6 lanes) or wide (8 lanes). Ten is not a multiple of any of these widths, so a residue store holds leftover pixels until they are sent, and a ready output stalls the source whenever the store cannot take a whole beat.

The block also produces the three stream qualifiers: a frame-valid that brackets a frame, a line-valid that brackets each line, and a data-valid that marks cycles whose active lanes are all filled. The source marks the last beat of a line and the last beat of a frame. When a line ends on a partial group, that group goes out in a final line-valid cycle with data-valid low and the unfilled lanes at zero. The tap mode is meant to change only between frames.

Top module: `pix_regear`

## Requirements
- R1: During and right after reset, all lanes, frame-valid, line-valid and data-valid are low and in_ready is high.
- R2: Each output lane value equals bits [9:2] of the input pixel it came from; input pixel i sits at bits [10*i+9 : 10*i] of the input word.
- R3: Tap mode 0 gives 3 lanes, mode 1 gives 6 lanes, modes 2 and 3 give 8 lanes; lanes at or above the active count are always zero. Lane i sits at bits [8*i+7 : 8*i] of the output word.
- R4: Pixels leave in ascending index order across beats of a line, with lane 0 carrying the lowest pixel not yet sent; no pixel is lost or repeated.
- R5: in_ready is low when the residue store cannot hold a whole new beat after this cycle's output, while the end of a line is still in the store, and in the cycle before frame-valid falls; a beat offered while in_ready is low is not taken.
- R6: line-valid is high from the first output cycle of a line through its last, including stall cycles inside the line in which no group is sent.
- R7: data-valid is high exactly on cycles that send a full group of active lanes; a partial last group of a line is sent with data-valid low, and all lanes are zero whenever line-valid is low.
- R8: frame-valid rises at least one cycle before the first line-valid of a frame and falls exactly one cycle after the last line-valid of that frame.
- R9: A tap mode applied while frame-valid is low governs every output cycle of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_mode | input | 2 | Output lane count select (0: 3, 1: 6, 2/3: 8) |
| in_pix | input | 100 | Ten 10-bit pixels, pixel 0 in the low bits |
| in_valid | input | 1 | Input beat offered |
| in_eol | input | 1 | Offered beat is the last of its line |
| in_eof | input | 1 | Offered beat is the last of its frame (implies end of line) |
| in_ready | output | 1 | Block takes the offered beat at this edge |
| out_pix | output | 64 | Eight 8-bit lanes, lane 0 in the low bits |
| out_fval | output | 1 | Frame valid |
| out_lval | output | 1 | Line valid |
| out_dval | output | 1 | Data valid |

## Verification
Frames are sent in every tap mode with line lengths chosen so that some lines end on an exact group boundary and others leave a remainder of one or two pixels, which separates correct flushing of a partial group from pixel loss or a stray extra cycle. Back-to-back beats drive the residue store to its limit and exercise the stall, while runs with random idle gaps between beats test that line-valid holds through underflow with data-valid low. Pixel values change their low two bits from beat to beat, so a wrong truncation slice or a lane-order swap shows up in the lane comparison against a queue-based model.

// File: rtl/pix_regear.sv
module pix_regear #(
  parameter int NPIX      = 10,
  parameter int IN_W      = 10,
  parameter int OUT_W     = 8,
  parameter int LANES_A   = 3,
  parameter int LANES_B   = 6,
  parameter int LANES_C   = 8,
  parameter int DEPTH     = NPIX + LANES_C - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 tap_mode,
  input  logic [NPIX*IN_W-1:0]       in_pix,
  input  logic                       in_valid,
  input  logic                       in_eol,
  input  logic                       in_eof,
  output logic                       in_ready,
  output logic [LANES_C*OUT_W-1:0]   out_pix,
  output logic                       out_fval,
  output logic                       out_lval,
  output logic                       out_dval
);
  localparam int CW   = $clog2(DEPTH + NPIX + 1);
  localparam int DROP = IN_W - OUT_W;

  logic [OUT_W-1:0] buf_q   [DEPTH];
  logic [OUT_W-1:0] buf_nxt [DEPTH];
  logic [OUT_W-1:0] lane_nxt[LANES_C];
  logic [CW-1:0]    cnt_q, lanes, take, rem;
  logic             eol_q, eof_q, fall_q, open_q, fval_q, lval_q, dval_q;
  logic             full_grp, emit, last_emit, acc;
  logic [LANES_C*OUT_W-1:0] pix_q;

  assign lanes = (tap_mode == 2'd0) ? CW'(LANES_A) :
                 (tap_mode == 2'd1) ? CW'(LANES_B) : CW'(LANES_C);

  assign full_grp  = cnt_q >= lanes;
  assign emit      = full_grp || (eol_q && cnt_q != '0);
  assign take      = !emit ? '0 : (full_grp ? lanes : cnt_q);
  assign rem       = cnt_q - take;
  assign last_emit = emit && eol_q && (cnt_q <= lanes);
  assign in_ready  = !eol_q && !fall_q && ((rem + CW'(NPIX)) <= CW'(DEPTH));
  assign acc       = in_valid && in_ready;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) buf_nxt[j] = '0;
    for (int k = 0; k < DEPTH; k++)
      if (k >= int'(take) && k < int'(cnt_q)) buf_nxt[k - int'(take)] = buf_q[k];
    if (acc)
      for (int p = 0; p < NPIX; p++)
        if (int'(rem) + p < DEPTH)
          buf_nxt[int'(rem) + p] = in_pix[p*IN_W + DROP +: OUT_W];
  end

  always_comb
    for (int i = 0; i < LANES_C; i++)
      lane_nxt[i] = (i < int'(take)) ? buf_q[i] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      eol_q  <= 1'b0;
      eof_q  <= 1'b0;
      fall_q <= 1'b0;
      open_q <= 1'b0;
      fval_q <= 1'b0;
      lval_q <= 1'b0;
      dval_q <= 1'b0;
      pix_q  <= '0;
      for (int j = 0; j < DEPTH; j++) buf_q[j] <= '0;
    end else begin
      for (int j = 0; j < DEPTH; j++) buf_q[j] <= buf_nxt[j];
      for (int i = 0; i < LANES_C; i++) pix_q[i*OUT_W +: OUT_W] <= lane_nxt[i];
      cnt_q  <= rem + (acc ? CW'(NPIX) : '0);
      if (acc) begin
        eol_q <= in_eol || in_eof;
        eof_q <= in_eof;
      end else if (last_emit) begin
        eol_q <= 1'b0;
        eof_q <= 1'b0;
      end
      fall_q <= last_emit && eof_q;
      if (acc)         fval_q <= 1'b1;
      else if (fall_q) fval_q <= 1'b0;
      if (emit) open_q <= !last_emit;
      lval_q <= emit || open_q;
      dval_q <= emit && full_grp;
    end
  end

  assign out_pix  = pix_q;
  assign out_fval = fval_q;
  assign out_lval = lval_q;
  assign out_dval = dval_q;
endmodule

// File: rtl/pix_regear_chk.sv
module pix_regear_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   tap_mode,
  input logic [W-1:0] out_pix,
  input logic         out_fval,
  input logic         out_lval,
  input logic         out_dval
);
  a_r8_fval_leads_lval: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_lval) |-> $past(out_fval));

  a_r8_fval_trails_lval: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_fval) |-> (!out_lval && $past(out_lval)));

  a_r7_dval_inside_line: assert property (@(posedge clk) disable iff (!rst_n)
    out_dval |-> out_lval);

  a_r7_idle_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_lval |-> (out_pix == '0));

  a_r9_mode_held_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fval && $past(out_fval)) |-> $stable(tap_mode));

  a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fval && tap_mode == 2'd0) |-> (out_pix[W-1:24] == '0));
endmodule

bind pix_regear pix_regear_chk #(.W(LANES_C*OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tap_mode(tap_mode), .out_pix(out_pix),
  .out_fval(out_fval), .out_lval(out_lval), .out_dval(out_dval)
);

// File: tb/pix_regear_bench.sv
module pix_regear_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tap_mode = 2'd0;
  logic [99:0] in_pix = '0;
  logic        in_valid = 1'b0, in_eol = 1'b0, in_eof = 1'b0;
  logic        in_ready;
  logic [63:0] out_pix;
  logic        out_fval, out_lval, out_dval;

  int checks = 0, errors = 0;
  bit done = 0;
  int seq = 0;

  always #5 clk = ~clk;

  pix_regear u_pix_regear (.*);

  // reference model state
  int q[$];
  bit m_eol, m_eof, m_fall, m_open, m_fval;
  int exp_lane[8];
  bit exp_fval, exp_lval, exp_dval;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete(); m_eol = 0; m_eof = 0; m_fall = 0; m_open = 0; m_fval = 0;
      for (int i = 0; i < 8; i++) exp_lane[i] = 0;
      exp_fval = 0; exp_lval = 0; exp_dval = 0;
      chk(out_pix == 0 && !out_fval && !out_lval && !out_dval && in_ready,
          "R1 reset state", int'(out_fval) + int'(out_lval) + int'(out_dval), 0);
    end else if (!done) begin
      int lanes, qs, take, nb;
      bit full, emit, last, rdy, acc;
      lanes = (tap_mode == 0) ? 3 : (tap_mode == 1) ? 6 : 8;
      qs = q.size();
      full = qs >= lanes;
      emit = full || (m_eol && qs > 0);
      take = !emit ? 0 : (full ? lanes : qs);
      last = emit && m_eol && qs <= lanes;
      rdy = !m_eol && !m_fall && (qs - take + 10 <= 17);
      for (int i = 0; i < 8; i++)
        chk(out_pix[i*8 +: 8] == exp_lane[i][7:0], (i >= lanes) ? "R3 lane" : "R2/R4 lane",
            int'(out_pix[i*8 +: 8]), exp_lane[i]);
      chk(out_fval == exp_fval, "R8 fval", int'(out_fval), int'(exp_fval));
      chk(out_lval == exp_lval, "R6 lval", int'(out_lval), int'(exp_lval));
      chk(out_dval == exp_dval, "R7 dval", int'(out_dval), int'(exp_dval));
      chk(in_ready == rdy, "R5 in_ready", int'(in_ready), int'(rdy));
      acc = in_valid && rdy;
      for (int i = 0; i < 8; i++) exp_lane[i] = (i < take) ? q[i] : 0;
      for (int i = 0; i < take; i++) void'(q.pop_front());
      if (acc)
        for (int p = 0; p < 10; p++) begin
          nb = int'(in_pix[p*10 +: 10]) >> 2;
          q.push_back(nb);
        end
      exp_dval = emit && full;
      exp_lval = emit || m_open;
      exp_fval = m_fval;
      if (emit) m_open = !last;
      if (acc) m_fval = 1;
      else if (m_fall) m_fval = 0;
      exp_fval = m_fval;
      m_fall = last && m_eof;
      if (acc) begin m_eol = in_eol || in_eof; m_eof = in_eof; end
      else if (last) begin m_eol = 0; m_eof = 0; end
    end
  end

  task automatic send_beat(bit eol, bit eof, bit gaps);
    bit rdy;
    if (gaps) begin
      int g = $urandom_range(0, 3);
      in_valid = 0;
      repeat (g) @(posedge clk);
      #1;
    end
    for (int p = 0; p < 10; p++) begin
      in_pix[p*10 +: 10] = 10'((seq * 37 + p * 113 + 5) & 1023);
    end
    seq++;
    in_valid = 1; in_eol = eol; in_eof = eof;
    do begin
      @(negedge clk); rdy = in_ready;
      @(posedge clk); #1;
    end while (!rdy);
    in_valid = 0; in_eol = 0; in_eof = 0;
  endtask

  task automatic send_frame(int mode, int lines, int beats, bit gaps);
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(!out_fval, "R9 fval low at mode change", int'(out_fval), 0);
    tap_mode = 2'(mode);
    repeat (2) @(posedge clk);
    #1;
    for (int l = 0; l < lines; l++)
      for (int b = 0; b < beats; b++)
        send_beat(b == beats - 1, (l == lines - 1) && (b == beats - 1), gaps);
    while (out_fval || in_ready == 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    send_frame(0, 2, 3, 0);
    send_frame(1, 3, 2, 0);
    send_frame(2, 2, 1, 0);
    send_frame(2, 2, 4, 0);
    send_frame(3, 2, 3, 0);
    send_frame(0, 3, 1, 1);
    send_frame(1, 2, 5, 1);
    send_frame(2, 3, 3, 1);
    send_frame(0, 2, 7, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule